// File: doc/BRIEF.md
# Bypassable Integer Clock-Enable Divider

This block divides one of two source clocks by a programmable integer and produces a one-cycle clock-enable pulse per output period. Both sources are modelled as tick strobes in a single clock domain. One tick strobe stands for a crystal reference and the other for a fractional reference. A select bit picks the source. Software changes the select bit only by toggling it, and the change waits for an output period boundary so that no period is cut short.

Each source path has its own divide field and its own busy flag. A new divide value is held as pending and is not used straight away. It is loaded when the running output period ends, followed by a short settle of two source ticks. The path's busy flag is high for that whole time. A gate bit masks the output pulses, and divide writes made while the gate is set are refused. An optional wait gating masks the pulses while a wait-for-interrupt input is high. Writes of zero to a divide field and writes refused because of the gate each set a sticky error flag.

Top module: `bypass_divider`

## Requirements
- R1: After reset, both divide values are 1, the crystal path is selected (src_is_xtal = 1), the gate and the wait gating are off, both busy flags and both error flags are 0, and clk_en_out is 0.
- R2: When the active divide value of the selected path is N, clk_en_out is high for exactly one cycle, in the cycle after every Nth tick of the selected source. Ticks of the source that is not selected have no effect.
- R3: A write to address 1 with data bit 0 = 1 inverts the requested select, and bit 0 = 0 leaves it unchanged. The requested select moves to src_is_xtal only at the end of an output period. src_is_xtal = 1 means the crystal tick drives the divider and 0 means the fractional tick drives it.
- R4: Address 2 holds the crystal-path divide value and address 3 holds the reference-path divide value. Each value applies only while its own path is selected.
- R5: An accepted divide write sets that path's busy flag in the next cycle. At the next end of an output period, two further ticks of the selected source pass with no output pulse. On the second tick, every busy path loads its pending value and clears its busy flag, and the count restarts.
- R6: A divide write of 0 leaves the divide value and the busy flag unchanged and sets err_zero, which stays set until reset. The zero check comes before the gate check.
- R7: Control register bit 0 (address 0) = 1 suppresses every output pulse while the period count keeps running. A nonzero divide write made while this bit is set is refused and sets err_gated, which stays set until reset.
- R8: When control bit 1 = 1 and wfi is high in the cycle where a period ends, that pulse is suppressed. When control bit 1 = 0, wfi has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_tick | input | 1 | One-cycle strobe per crystal source cycle |
| ref_tick | input | 1 | One-cycle strobe per fractional reference cycle |
| wfi | input | 1 | Wait-for-interrupt indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 toggle, 2 crystal divide, 3 reference divide |
| wr_data | input | DIV_W | Write data |
| clk_en_out | output | 1 | Divided clock-enable pulse |
| busy_xtal | output | 1 | Crystal-path divide change in progress |
| busy_ref | output | 1 | Reference-path divide change in progress |
| src_is_xtal | output | 1 | Source currently driving the divider |
| err_zero | output | 1 | Sticky flag: a zero divide write occurred |
| err_gated | output | 1 | Sticky flag: a divide write was refused by the gate |

## Verification
The first error in a wrong period count or a wrong pending ratio shows on clk_en_out at the next period boundary. The pulse then arrives early or late by at least one source tick, and every later pulse is offset as well. A lost or stuck busy flag shows on busy_xtal or busy_ref the cycle after the faulty event. It also moves the settle window, which removes or adds a pulse within the next two output periods. A select that changes at the wrong time shows on src_is_xtal in the same cycle, before any pulse is affected.

// File: rtl/bid_pkg.sv
package bid_pkg;
  typedef enum logic [1:0] {
    A_CTRL     = 2'd0,
    A_TOGGLE   = 2'd1,
    A_DIV_XTAL = 2'd2,
    A_DIV_REF  = 2'd3
  } bid_addr_e;

  localparam int SETTLE_TICKS = 2;
  localparam int SETTLE_W     = 2;
  localparam int PATH_REF     = 0;
  localparam int PATH_XTAL    = 1;
  localparam int NUM_PATHS    = 2;
endpackage

// File: rtl/bid_cfg.sv
module bid_cfg
  import bid_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DIV_W-1:0] wr_data,
  output logic             gate_q,
  output logic             wait_en_q,
  output logic             sel_req_q,
  output logic [NUM_PATHS-1:0] div_accept,
  output logic             err_zero,
  output logic             err_gated
);
  logic div_write;
  logic div_zero;
  logic div_refused;

  function automatic logic is_div_addr(input logic [1:0] a);
    return (a == A_DIV_XTAL) || (a == A_DIV_REF);
  endfunction

  assign div_write   = wr_en && is_div_addr(wr_addr);
  assign div_zero    = div_write && (wr_data == '0);
  assign div_refused = div_write && !div_zero && gate_q;

  always_comb begin
    div_accept = '0;
    if (div_write && !div_zero && !gate_q) begin
      div_accept[PATH_XTAL] = (wr_addr == A_DIV_XTAL);
      div_accept[PATH_REF]  = (wr_addr == A_DIV_REF);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q    <= 1'b0;
      wait_en_q <= 1'b0;
      sel_req_q <= 1'b1;
      err_zero  <= 1'b0;
      err_gated <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) begin
        gate_q    <= wr_data[0];
        wait_en_q <= wr_data[1];
      end
      if (wr_en && wr_addr == A_TOGGLE && wr_data[0])
        sel_req_q <= ~sel_req_q;
      if (div_zero)    err_zero  <= 1'b1;
      if (div_refused) err_gated <= 1'b1;
    end
  end

  // R6: the zero-write flag never drops once raised
  a_r6_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_zero) |-> err_zero);
  // R7: the refused-write flag never drops once raised
  a_r7_gated_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_gated) |-> err_gated);
  // R7: no divide write is accepted while the gate is set
  a_r7_no_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> div_accept == '0);
endmodule

// File: rtl/bid_slot.sv
module bid_slot #(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_accept,
  input  logic [DIV_W-1:0] wr_value,
  input  logic             apply,
  output logic [DIV_W-1:0] ratio,
  output logic             busy
);
  logic [DIV_W-1:0] pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio   <= DIV_W'(DIV_RESET);
      pending <= DIV_W'(DIV_RESET);
      busy    <= 1'b0;
    end else begin
      if (apply && busy) ratio <= pending;
      if (wr_accept) begin
        pending <= wr_value;
        busy    <= 1'b1;
      end else if (apply) begin
        busy <= 1'b0;
      end
    end
  end

  // R5: an accepted write raises busy on the next cycle
  a_r5_busy_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> busy);
  // R6: the active ratio is never zero
  a_r6_ratio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    ratio != '0);
  // R5: the ratio changes only while a change is in progress
  a_r5_ratio_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio) |-> $past(busy));
endmodule

// File: rtl/bid_core.sv
module bid_core
  import bid_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_tick,
  input  logic             ref_tick,
  input  logic             wfi,
  input  logic             gate,
  input  logic             wait_en,
  input  logic             sel_req,
  input  logic [DIV_W-1:0] ratio_xtal,
  input  logic [DIV_W-1:0] ratio_ref,
  input  logic             any_busy,
  output logic             apply,
  output logic             sel_act,
  output logic             clk_en_out
);
  logic [DIV_W-1:0]    cnt_q;
  logic [SETTLE_W-1:0] settle_left;
  logic                tick_sel;
  logic [DIV_W-1:0]    limit;
  logic                settling;
  logic                period_end;
  logic                pulse_mask;

  function automatic logic last_tick(input logic [DIV_W-1:0] c,
                                     input logic [DIV_W-1:0] lim);
    return c == (lim - DIV_W'(1));
  endfunction

  assign tick_sel   = sel_act ? xtal_tick : ref_tick;
  assign limit      = sel_act ? ratio_xtal : ratio_ref;
  assign settling   = (settle_left != '0);
  assign period_end = !settling && tick_sel && last_tick(cnt_q, limit);
  assign apply      = settling && tick_sel && (settle_left == SETTLE_W'(1));
  assign pulse_mask = gate || (wait_en && wfi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      settle_left <= '0;
      sel_act     <= 1'b1;
      clk_en_out  <= 1'b0;
    end else begin
      clk_en_out <= period_end && !pulse_mask;
      if (period_end) begin
        cnt_q   <= '0;
        sel_act <= sel_req;
        if (any_busy) settle_left <= SETTLE_W'(SETTLE_TICKS);
      end else if (!settling && tick_sel) begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
      if (settling && tick_sel) settle_left <= settle_left - SETTLE_W'(1);
    end
  end

  // R7: no pulse follows a cycle with the gate set
  a_r7_no_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |-> !$past(gate));
  // R8: no pulse follows a cycle with wait gating active
  a_r8_wait_mask: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |-> !$past(wait_en && wfi));
  // R5: no pulse is produced from a settle cycle
  a_r5_quiet_settle: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |-> !$past(settling));
  // R3: the source changes only with the count at its start
  a_r3_switch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_act) |-> cnt_q == '0);
  // R2: the count stays below the active limit outside a ratio change
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !settling && !any_busy |-> cnt_q < limit);
endmodule

// File: rtl/bypass_divider.sv
module bypass_divider
  import bid_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_tick,
  input  logic             ref_tick,
  input  logic             wfi,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DIV_W-1:0] wr_data,
  output logic             clk_en_out,
  output logic             busy_xtal,
  output logic             busy_ref,
  output logic             src_is_xtal,
  output logic             err_zero,
  output logic             err_gated
);
  logic                 gate_q;
  logic                 wait_en_q;
  logic                 sel_req_q;
  logic                 apply;
  logic [NUM_PATHS-1:0] div_accept;
  logic [NUM_PATHS-1:0] busy_vec;
  logic [DIV_W-1:0]     ratio_vec [NUM_PATHS];

  bid_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gate_q(gate_q), .wait_en_q(wait_en_q),
    .sel_req_q(sel_req_q), .div_accept(div_accept),
    .err_zero(err_zero), .err_gated(err_gated)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    bid_slot #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_accept(div_accept[p]),
      .wr_value(wr_data), .apply(apply),
      .ratio(ratio_vec[p]), .busy(busy_vec[p])
    );
  end

  bid_core #(.DIV_W(DIV_W)) u_core (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .ref_tick(ref_tick),
    .wfi(wfi), .gate(gate_q), .wait_en(wait_en_q), .sel_req(sel_req_q),
    .ratio_xtal(ratio_vec[PATH_XTAL]), .ratio_ref(ratio_vec[PATH_REF]),
    .any_busy(|busy_vec), .apply(apply), .sel_act(src_is_xtal),
    .clk_en_out(clk_en_out)
  );

  assign busy_xtal = busy_vec[PATH_XTAL];
  assign busy_ref  = busy_vec[PATH_REF];

  // R5: a busy flag clears only on the settle tick that loads the new ratio
  a_r5_busy_clear_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_xtal) |-> $past(apply));
endmodule

// File: tb/bypass_divider_test.sv
module bypass_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_tick = 1'b0, ref_tick = 1'b0, wfi = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic clk_en_out, busy_xtal, busy_ref, src_is_xtal, err_zero, err_gated;

  int checks = 0;
  int errors = 0;
  string ptag = "R2";

  // reference model state, index 1 = crystal path, 0 = reference path
  logic m_gate, m_wen, m_req, m_sel, m_out, m_ez, m_eg;
  int   m_act [2];
  int   m_pnd [2];
  logic m_busy [2];
  int   m_pos, m_hold;

  bypass_divider #(.DIV_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .ref_tick(ref_tick),
    .wfi(wfi), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_en_out(clk_en_out), .busy_xtal(busy_xtal), .busy_ref(busy_ref),
    .src_is_xtal(src_is_xtal), .err_zero(err_zero), .err_gated(err_gated)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_gate = 0; m_wen = 0; m_req = 1; m_sel = 1; m_out = 0; m_ez = 0; m_eg = 0;
    for (int p = 0; p < 2; p++) begin m_act[p] = 1; m_pnd[p] = 1; m_busy[p] = 0; end
    m_pos = 0; m_hold = 0;
  endtask

  // one clock edge of the required behaviour, using pre-edge state
  task automatic model_step();
    logic old_gate, old_req, tk;
    int s;
    old_gate = m_gate; old_req = m_req; s = m_sel ? 1 : 0;
    tk = m_sel ? xtal_tick : ref_tick;
    m_out = 0;
    if (m_hold == 0) begin
      if (tk) begin
        if (m_pos + 1 == m_act[s]) begin
          m_out = !(old_gate || (m_wen && wfi));
          m_pos = 0;
          m_sel = old_req;
          if (m_busy[0] || m_busy[1]) m_hold = 2;
        end else m_pos++;
      end
    end else if (tk) begin
      m_hold--;
      if (m_hold == 0)
        for (int p = 0; p < 2; p++)
          if (m_busy[p]) begin m_act[p] = m_pnd[p]; m_busy[p] = 0; end
    end
    if (wr_en) begin
      case (wr_addr)
        2'd0: begin m_gate = wr_data[0]; m_wen = wr_data[1]; end
        2'd1: if (wr_data[0]) m_req = !old_req;
        default: begin
          int p;
          p = (wr_addr == 2'd2) ? 1 : 0;
          if (wr_data == 0) m_ez = 1;
          else if (old_gate) m_eg = 1;
          else begin m_pnd[p] = int'(wr_data); m_busy[p] = 1; end
        end
      endcase
    end
  endtask

  task automatic compare_all();
    check(ptag, "clk_en_out", int'(clk_en_out), int'(m_out));
    check("R5", "busy_xtal", int'(busy_xtal), int'(m_busy[1]));
    check("R5", "busy_ref", int'(busy_ref), int'(m_busy[0]));
    check("R3", "src_is_xtal", int'(src_is_xtal), int'(m_sel));
    check("R6", "err_zero", int'(err_zero), int'(m_ez));
    check("R7", "err_gated", int'(err_gated), int'(m_eg));
  endtask

  // called at a falling edge; ends at the next falling edge after checking
  task automatic cyc(input logic xt, input logic rt, input logic wf,
                     input logic we, input logic [1:0] wa, input logic [DW-1:0] wd);
    xtal_tick = xt; ref_tick = rt; wfi = wf;
    wr_en = we; wr_addr = wa; wr_data = wd;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic ticks(input int n, input logic xt, input logic rt);
    for (int i = 0; i < n; i++) cyc(xt, rt, 1'b0, 1'b0, 2'd0, '0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, a, d);
  endtask

  initial begin
    void'($urandom(32'h1234_abcd));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    check("R1", "clk_en_out", int'(clk_en_out), 0);
    check("R1", "busy", int'(busy_xtal | busy_ref), 0);
    check("R1", "src_is_xtal", int'(src_is_xtal), 1);
    check("R1", "errors", int'(err_zero | err_gated), 0);
    ptag = "R1";
    ticks(4, 1'b1, 1'b0);          // ratio 1: one pulse per crystal tick

    // R4: separate divide fields per path, ref ticks ignored while on crystal
    ptag = "R4";
    wr(2'd3, 8'd3);
    wr(2'd2, 8'd2);
    ticks(12, 1'b1, 1'b1);
    ticks(6, 1'b0, 1'b1);
    // R3: toggle to reference, zero-data toggle changes nothing
    ptag = "R3";
    wr(2'd1, 8'd0);
    ticks(3, 1'b1, 1'b0);
    wr(2'd1, 8'd1);
    ticks(2, 1'b1, 1'b0);
    ticks(10, 1'b0, 1'b1);
    ticks(4, 1'b1, 1'b0);

    // R6: zero writes ignored
    ptag = "R6";
    wr(2'd2, 8'd0);
    wr(2'd3, 8'd0);
    ticks(9, 1'b0, 1'b1);

    // R7: gate suppresses pulses and refuses divide writes
    ptag = "R7";
    wr(2'd0, 8'd1);
    ticks(7, 1'b0, 1'b1);
    wr(2'd3, 8'd5);
    ticks(7, 1'b0, 1'b1);
    wr(2'd0, 8'd0);
    ticks(7, 1'b0, 1'b1);

    // R8: wait gating
    ptag = "R8";
    wr(2'd0, 8'd2);
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1, i[2], 1'b0, 2'd0, '0);
    wr(2'd0, 8'd0);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'd0, '0);

    // R5 and R2: random mix of ticks, writes, toggles and gating
    ptag = "R2";
    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [1:0] wa;
      logic [DW-1:0] wd;
      we = ($urandom % 12) == 0;
      wa = 2'($urandom % 4);
      if (wa == 2'd0) wd = DW'(($urandom % 4) == 0 ? 1 : ($urandom % 2) * 2);
      else wd = DW'($urandom % 7);
      cyc(1'($urandom % 2), 1'($urandom % 3 != 0), 1'($urandom % 4 == 0), we, wa, wd);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule